// File: doc/BRIEF.md
# PCIe Advisory Error Logging Unit

This block sits next to the transaction layer of a PCIe endpoint. It takes single-cycle error pulses for four completion-side error types:
- completion timeout
- completer-abort completion status
- unexpected completion
- unsupported-request completion status

For each pulse it decides whether the error is fatal, a plain non-fatal uncorrectable error, or an advisory non-fatal error. Advisory errors are recorded in the uncorrectable registers but are reported upstream only as a correctable message.

The unit holds the following registers:
- a one-bit advisory flag in a correctable status register, with a mask beside it
- uncorrectable status, mask and severity registers
- a first-error pointer and a multi-word header log

The header log stays locked while the status bit it points at is still set. Software reads and writes these registers through a simple address/data port. The status registers are write-1-to-clear. One registered pulse per message class asks the transmit logic to send a correctable, non-fatal or fatal error message. Each pulse is qualified by its device-control enable input.

Top module: `pcie_adv_err_log`

## Requirements
- R1: After reset, every readable register (addresses 0 to 5 and the header words) reads zero and no message pulse is raised.
- R2: An advisory event sets bit 0 of the correctable status (address 0). When bit 0 of the correctable mask (address 1) is clear, it also sets its type's bit in the uncorrectable status (address 2). Bit positions are: 0 completion timeout, 1 completer abort, 2 unexpected completion, 3 unsupported request.
- R3: When a set uncorrectable status bit is unmasked in the uncorrectable mask (address 3) and the log is free, the first-error pointer (address 5, bits 1:0) takes the error type. Header word k (`hdr_in[32k+31:32k]`) is captured at address 6+k.
- R4: The log is busy while the status bit named by the pointer is set. While busy, the pointer and header words do not change. Clearing that bit by writing 1 frees the log for the next error.
- R5: `msg_cor` pulses in the cycle after an advisory event, only when `en_cor` is 1 and the advisory mask bit is clear. An advisory event never raises `msg_nonfatal`.
- R6: Classification uses the severity bit (0 means non-fatal). A non-fatal completer abort, unsupported request or unexpected completion is always advisory. A non-fatal completion timeout is advisory only when `cto_retry` is 1. Without retry it sets its status bit, leaves the correctable status alone, and pulses `msg_nonfatal` when `en_nonfatal` is 1 and its mask bit is clear.
- R7: An event whose severity bit (address 4) is 1 sets its uncorrectable status bit and leaves the correctable status unchanged. It pulses `msg_fatal` in the next cycle when `en_fatal` is 1 and its mask bit is clear.
- R8: Events arriving in the same cycle all set their status bits. Only the lowest-numbered one among those eligible to log may claim a free pointer.
- R9: Writing 1 to a status bit clears it, and a status bit set in the same cycle wins over the clear. The mask and severity registers read back the value written (bit 0 at address 1, bits 3:0 at addresses 3 and 4).
- R10: An error whose uncorrectable mask bit is set still sets its status bit. It does not touch the pointer or header log, and raises no non-fatal or fatal message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_cto | input | 1 | Completion timeout pulse |
| cto_retry | input | 1 | Requester will retry the timed-out request |
| ev_ca | input | 1 | Completer-abort completion pulse |
| ev_uc | input | 1 | Unexpected completion pulse |
| ev_ur | input | 1 | Unsupported-request completion pulse |
| hdr_in | input | HDR_WORDS*WORD_W | Header of the offending packet, valid with the event |
| en_cor | input | 1 | Device control: correctable reporting enable |
| en_nonfatal | input | 1 | Device control: non-fatal reporting enable |
| en_fatal | input | 1 | Device control: fatal reporting enable |
| reg_addr | input | ADDR_W | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | WORD_W | Register write data |
| reg_rdata | output | WORD_W | Register read data (combinational) |
| msg_cor | output | 1 | Request a correctable error message |
| msg_nonfatal | output | 1 | Request a non-fatal error message |
| msg_fatal | output | 1 | Request a fatal error message |

## Verification
The bench builds the unit with its defaults: four 32-bit header words and a 4-bit address. This places all four header words in the same read window as the status, mask and severity registers, so every random read can land on any stored state. Random severity and mask writes, together with random write-1-to-clear data, drive the log through many lock and release cycles. They also produce many same-cycle event mixes, where both the priority claim and the set-beats-clear rule come into play.

// File: rtl/pael_pkg.sv
package pael_pkg;
   localparam int unsigned N_ERR = 4;

   typedef enum logic [1:0] {
      ERR_CTO = 2'd0,
      ERR_CA  = 2'd1,
      ERR_UC  = 2'd2,
      ERR_UR  = 2'd3
   } err_id_e;

   localparam int unsigned A_COR_STAT = 0;
   localparam int unsigned A_COR_MASK = 1;
   localparam int unsigned A_UNC_STAT = 2;
   localparam int unsigned A_UNC_MASK = 3;
   localparam int unsigned A_UNC_SEV  = 4;
   localparam int unsigned A_FEP      = 5;
   localparam int unsigned A_HDR_BASE = 6;
endpackage

// File: rtl/pael_classify.sv
module pael_classify
   import pael_pkg::*;
(
   input  logic [N_ERR-1:0] ev,
   input  logic [N_ERR-1:0] sev,
   input  logic             cto_retry,
   output logic [N_ERR-1:0] adv,
   output logic [N_ERR-1:0] nonfatal,
   output logic [N_ERR-1:0] fatal
);
   for (genvar g = 0; g < N_ERR; g++) begin : g_cls
      assign fatal[g] = ev[g] & sev[g];
      if (g == int'(ERR_CTO)) begin : g_timeout
         // timeout is advisory only when the requester retries
         assign adv[g]      = ev[g] & ~sev[g] &  cto_retry;
         assign nonfatal[g] = ev[g] & ~sev[g] & ~cto_retry;
      end else begin : g_completion
         assign adv[g]      = ev[g] & ~sev[g];
         assign nonfatal[g] = 1'b0;
      end
   end
endmodule

// File: rtl/pael_regs.sv
module pael_regs
   import pael_pkg::*;
#(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              set_cor,
   input  logic [N_ERR-1:0]  set_unc,
   output logic              cor_stat,
   output logic              cor_mask,
   output logic [N_ERR-1:0]  unc_stat,
   output logic [N_ERR-1:0]  unc_mask,
   output logic [N_ERR-1:0]  unc_sev
);
   logic hit_cstat, hit_cmask, hit_ustat, hit_umask, hit_usev;
   logic [N_ERR-1:0] unc_clr;
   logic             cor_clr;

   assign hit_cstat = wr_en && (wr_addr == ADDR_W'(A_COR_STAT));
   assign hit_cmask = wr_en && (wr_addr == ADDR_W'(A_COR_MASK));
   assign hit_ustat = wr_en && (wr_addr == ADDR_W'(A_UNC_STAT));
   assign hit_umask = wr_en && (wr_addr == ADDR_W'(A_UNC_MASK));
   assign hit_usev  = wr_en && (wr_addr == ADDR_W'(A_UNC_SEV));

   assign cor_clr = hit_cstat & wr_data[0];
   assign unc_clr = hit_ustat ? wr_data[N_ERR-1:0] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cor_stat <= 1'b0;
         cor_mask <= 1'b0;
         unc_stat <= '0;
         unc_mask <= '0;
         unc_sev  <= '0;
      end else begin
         cor_stat <= (cor_stat & ~cor_clr) | set_cor;
         unc_stat <= (unc_stat & ~unc_clr) | set_unc;
         if (hit_cmask) cor_mask <= wr_data[0];
         if (hit_umask) unc_mask <= wr_data[N_ERR-1:0];
         if (hit_usev)  unc_sev  <= wr_data[N_ERR-1:0];
      end
   end

   // R2
   adv_sets_cor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_cor |=> cor_stat);

   // R9
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_addr == ADDR_W'(A_UNC_MASK)) |=> $stable(unc_mask));
endmodule

// File: rtl/pael_hdr_log.sv
module pael_hdr_log
   import pael_pkg::*;
#(
   parameter int unsigned HDR_WORDS = 4,
   parameter int unsigned WORD_W    = 32,
   localparam int unsigned FEP_W    = $clog2(N_ERR),
   localparam int unsigned HDR_W    = HDR_WORDS * WORD_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_ERR-1:0] log_req,
   input  logic [N_ERR-1:0] unc_stat,
   input  logic [HDR_W-1:0] hdr_in,
   output logic [FEP_W-1:0] fep,
   output logic [HDR_W-1:0] hdr_log
);
   logic [FEP_W-1:0] pick;
   logic             any_req;
   logic             busy;

   always_comb begin
      pick    = '0;
      any_req = |log_req;
      for (int i = N_ERR - 1; i >= 0; i--) begin
         if (log_req[i]) pick = FEP_W'(i);
      end
   end

   assign busy = unc_stat[fep];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fep     <= '0;
         hdr_log <= '0;
      end else if (any_req && !busy) begin
         fep     <= pick;
         hdr_log <= hdr_in;
      end
   end

   // R4
   log_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(fep) && $stable(hdr_log)));

   // R3
   first_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && any_req) |=> unc_stat[fep]);
endmodule

// File: rtl/pcie_adv_err_log.sv
module pcie_adv_err_log
   import pael_pkg::*;
#(
   parameter int unsigned HDR_WORDS = 4,
   parameter int unsigned WORD_W    = 32,
   parameter int unsigned ADDR_W    = 4,
   localparam int unsigned FEP_W    = $clog2(N_ERR),
   localparam int unsigned HDR_W    = HDR_WORDS * WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_cto,
   input  logic              cto_retry,
   input  logic              ev_ca,
   input  logic              ev_uc,
   input  logic              ev_ur,
   input  logic [HDR_W-1:0]  hdr_in,
   input  logic              en_cor,
   input  logic              en_nonfatal,
   input  logic              en_fatal,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [WORD_W-1:0] reg_wdata,
   output logic [WORD_W-1:0] reg_rdata,
   output logic              msg_cor,
   output logic              msg_nonfatal,
   output logic              msg_fatal
);
   if (WORD_W < N_ERR) begin : g_bad_word
      $error("WORD_W must hold every error status bit");
   end
   if ((2 ** ADDR_W) < (A_HDR_BASE + HDR_WORDS)) begin : g_bad_addr
      $error("ADDR_W too small for the header log window");
   end
   if (HDR_WORDS < 1) begin : g_bad_hdr
      $error("HDR_WORDS must be at least 1");
   end

   logic [N_ERR-1:0] ev_vec, adv, nonfatal, fatal;
   logic [N_ERR-1:0] set_unc, log_req;
   logic             set_cor;
   logic             cor_stat, cor_mask;
   logic [N_ERR-1:0] unc_stat, unc_mask, unc_sev;
   logic [FEP_W-1:0] fep;
   logic [HDR_W-1:0] hdr_log;

   assign ev_vec = {ev_ur, ev_uc, ev_ca, ev_cto};

   pael_classify i_cls (
      .ev        (ev_vec),
      .sev       (unc_sev),
      .cto_retry (cto_retry),
      .adv       (adv),
      .nonfatal  (nonfatal),
      .fatal     (fatal)
   );

   // advisory errors reach the uncorrectable status only past the advisory mask
   assign set_cor = |adv;
   assign set_unc = fatal | nonfatal | (adv & {N_ERR{~cor_mask}});
   assign log_req = set_unc & ~unc_mask;

   pael_regs #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) i_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_we),
      .wr_addr  (reg_addr),
      .wr_data  (reg_wdata),
      .set_cor  (set_cor),
      .set_unc  (set_unc),
      .cor_stat (cor_stat),
      .cor_mask (cor_mask),
      .unc_stat (unc_stat),
      .unc_mask (unc_mask),
      .unc_sev  (unc_sev)
   );

   pael_hdr_log #(.HDR_WORDS(HDR_WORDS), .WORD_W(WORD_W)) i_log (
      .clk      (clk),
      .rst_n    (rst_n),
      .log_req  (log_req),
      .unc_stat (unc_stat),
      .hdr_in   (hdr_in),
      .fep      (fep),
      .hdr_log  (hdr_log)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         msg_cor      <= 1'b0;
         msg_nonfatal <= 1'b0;
         msg_fatal    <= 1'b0;
      end else begin
         msg_cor      <= en_cor & set_cor & ~cor_mask;
         msg_nonfatal <= en_nonfatal & |(nonfatal & ~unc_mask);
         msg_fatal    <= en_fatal & |(fatal & ~unc_mask);
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_W'(A_COR_STAT): reg_rdata[0] = cor_stat;
         ADDR_W'(A_COR_MASK): reg_rdata[0] = cor_mask;
         ADDR_W'(A_UNC_STAT): reg_rdata[N_ERR-1:0] = unc_stat;
         ADDR_W'(A_UNC_MASK): reg_rdata[N_ERR-1:0] = unc_mask;
         ADDR_W'(A_UNC_SEV):  reg_rdata[N_ERR-1:0] = unc_sev;
         ADDR_W'(A_FEP):      reg_rdata[FEP_W-1:0] = fep;
         default: begin
            for (int k = 0; k < int'(HDR_WORDS); k++) begin
               if (reg_addr == ADDR_W'(A_HDR_BASE + k))
                  reg_rdata = hdr_log[k*WORD_W +: WORD_W];
            end
         end
      endcase
   end

   // R5
   adv_no_nonfatal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msg_nonfatal |-> $past(ev_cto && !cto_retry));

   // R5
   cor_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msg_cor |-> $past(en_cor));

   // R7
   fatal_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msg_fatal |-> $past(en_fatal));
endmodule

// File: tb/test_pcie_adv_err_log.sv
module test_pcie_adv_err_log;
   localparam int HW = 4;
   localparam int WW = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ev_cto = 0, cto_retry = 0, ev_ca = 0, ev_uc = 0, ev_ur = 0;
   logic [HW*WW-1:0] hdr_in = '0;
   logic en_cor = 0, en_nonfatal = 0, en_fatal = 0;
   logic [3:0] reg_addr = '0;
   logic reg_we = 0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic msg_cor, msg_nonfatal, msg_fatal;

   int n_vec = 0;
   int n_bad = 0;

   // reference state
   logic       m_cstat = 0, m_cmask = 0;
   logic [3:0] m_ustat = 0, m_umask = 0, m_sev = 0;
   logic [1:0] m_fep = 0;
   logic [HW*WW-1:0] m_hdr = '0;
   logic x_cor = 0, x_nf = 0, x_fat = 0;

   pcie_adv_err_log i_pcie_adv_err_log (
      .clk(clk), .rst_n(rst_n), .ev_cto(ev_cto), .cto_retry(cto_retry),
      .ev_ca(ev_ca), .ev_uc(ev_uc), .ev_ur(ev_ur), .hdr_in(hdr_in),
      .en_cor(en_cor), .en_nonfatal(en_nonfatal), .en_fatal(en_fatal),
      .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .msg_cor(msg_cor), .msg_nonfatal(msg_nonfatal),
      .msg_fatal(msg_fatal)
   );

   always #10 clk = ~clk;

   initial begin
      #(20 * 200000);
      n_bad++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   function automatic logic [31:0] model_read(input logic [3:0] a);
      logic [31:0] r = '0;
      case (a)
         4'd0: r[0] = m_cstat;
         4'd1: r[0] = m_cmask;
         4'd2: r[3:0] = m_ustat;
         4'd3: r[3:0] = m_umask;
         4'd4: r[3:0] = m_sev;
         4'd5: r[1:0] = m_fep;
         4'd6, 4'd7, 4'd8, 4'd9: r = m_hdr[(int'(a) - 6)*WW +: WW];
         default: r = '0;
      endcase
      return r;
   endfunction

   function automatic string tag_of(input logic [3:0] a);
      case (a)
         4'd0: return "R2";
         4'd1, 4'd3, 4'd4: return "R9";
         4'd2: return "R8";
         4'd5: return "R3";
         default: return "R4";
      endcase
   endfunction

   function automatic logic [HW*WW-1:0] rnd_hdr();
      logic [HW*WW-1:0] h;
      for (int k = 0; k < HW; k++) h[k*WW +: WW] = $urandom;
      return h;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // one clock cycle: check last cycle's messages, drive, read, update model
   task automatic step(input logic [3:0] ev, input logic retry, input logic [HW*WW-1:0] h,
                       input logic we, input logic [3:0] a, input logic [31:0] wd,
                       input string tag, input logic ec, input logic enf, input logic efat);
      logic [3:0] adv, nf, fat, set_unc, logc, clr;
      logic       free;
      @(negedge clk);
      check("R5 msg_cor", {31'd0, msg_cor}, {31'd0, x_cor});
      check("R6 msg_nonfatal", {31'd0, msg_nonfatal}, {31'd0, x_nf});
      check("R7 msg_fatal", {31'd0, msg_fatal}, {31'd0, x_fat});
      {ev_ur, ev_uc, ev_ca, ev_cto} = ev;
      cto_retry = retry; hdr_in = h; reg_we = we; reg_addr = a; reg_wdata = wd;
      en_cor = ec; en_nonfatal = enf; en_fatal = efat;
      #1;
      if (!we) check(tag == "" ? tag_of(a) : tag, reg_rdata, model_read(a));
      for (int i = 0; i < 4; i++) begin
         fat[i] = ev[i] & m_sev[i];
         adv[i] = ev[i] & ~m_sev[i] & ((i != 0) | retry);
         nf[i]  = ev[i] & ~m_sev[i] & (i == 0) & ~retry;
      end
      set_unc = fat | nf | (m_cmask ? 4'b0 : adv);
      logc = set_unc & ~m_umask;
      free = ~m_ustat[m_fep];
      x_cor = ec & (|adv) & ~m_cmask;
      x_nf  = enf & |(nf & ~m_umask);
      x_fat = efat & |(fat & ~m_umask);
      if (free && |logc) begin
         for (int i = 3; i >= 0; i--) if (logc[i]) m_fep = 2'(i);
         m_hdr = h;
      end
      clr = (we && a == 4'd2) ? wd[3:0] : 4'b0;
      m_cstat = (m_cstat & ~(we && a == 4'd0 && wd[0])) | (|adv);
      m_ustat = (m_ustat & ~clr) | set_unc;
      if (we && a == 4'd1) m_cmask = wd[0];
      if (we && a == 4'd3) m_umask = wd[3:0];
      if (we && a == 4'd4) m_sev = wd[3:0];
   endtask

   task automatic idle_rd(input logic [3:0] a, input string tag);
      step(4'b0, 1'b0, '0, 1'b0, a, '0, tag, 1'b1, 1'b1, 1'b1);
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      step(4'b0, 1'b0, '0, 1'b1, a, d, "", 1'b1, 1'b1, 1'b1);
   endtask

   task automatic ev_rd(input logic [3:0] ev, input logic retry, input logic [3:0] a,
                        input string tag, input logic ec);
      step(ev, retry, rnd_hdr(), 1'b0, a, '0, tag, ec, 1'b1, 1'b1);
   endtask

   initial begin
      void'($urandom(32'd2718));
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      // R1: reset values
      for (int a = 0; a < 10; a++) idle_rd(4'(a), "R1");
      // R2/R3/R5: advisory unsupported request logs and requests ERR_COR
      ev_rd(4'b1000, 1'b0, 4'd0, "R1", 1'b1);
      idle_rd(4'd0, "R2");
      idle_rd(4'd5, "R3");
      // R4: log locked while UR status is set
      ev_rd(4'b0100, 1'b0, 4'd6, "R4", 1'b1);
      idle_rd(4'd5, "R4");
      idle_rd(4'd6, "R4");
      idle_rd(4'd2, "R2");
      wr(4'd2, 32'h8);
      ev_rd(4'b0010, 1'b0, 4'd5, "R4", 1'b0);   // R5: en_cor low, no message
      idle_rd(4'd5, "R3");
      idle_rd(4'd7, "R3");
      // R6: timeout without then with retry
      ev_rd(4'b0001, 1'b0, 4'd0, "R6", 1'b1);
      idle_rd(4'd2, "R6");
      wr(4'd0, 32'h1);
      ev_rd(4'b0001, 1'b1, 4'd0, "R6", 1'b1);
      idle_rd(4'd0, "R6");
      // R2: advisory mask blocks uncorrectable status and ERR_COR
      wr(4'd2, 32'hF);
      wr(4'd1, 32'h1);
      ev_rd(4'b1000, 1'b0, 4'd1, "R9", 1'b1);
      idle_rd(4'd2, "R2");
      idle_rd(4'd0, "R2");
      wr(4'd1, 32'h0);
      // R10: masked unexpected completion; R7: fatal completer abort
      wr(4'd3, 32'h4);
      wr(4'd4, 32'h2);
      wr(4'd2, 32'hF);
      wr(4'd0, 32'h1);
      idle_rd(4'd6, "R10");
      ev_rd(4'b0100, 1'b0, 4'd2, "R10", 1'b1);
      idle_rd(4'd2, "R10");
      idle_rd(4'd6, "R10");
      ev_rd(4'b0010, 1'b0, 4'd5, "R7", 1'b1);
      idle_rd(4'd0, "R7");
      idle_rd(4'd5, "R7");
      // R8: simultaneous events, lowest eligible claims; R9 set beats clear
      wr(4'd3, 32'h0);
      wr(4'd2, 32'hF);
      step(4'b1110, 1'b0, rnd_hdr(), 1'b1, 4'd2, 32'hF, "", 1'b1, 1'b1, 1'b1);
      idle_rd(4'd2, "R8");
      idle_rd(4'd5, "R8");
      idle_rd(4'd4, "R9");
      // constrained random
      for (int n = 0; n < 4000; n++) begin
         logic [3:0] ev;
         logic we;
         logic [3:0] a;
         for (int i = 0; i < 4; i++) ev[i] = ($urandom_range(0, 4) == 0);
         we = ($urandom_range(0, 5) == 0);
         a = we ? 4'($urandom_range(0, 4)) : 4'($urandom_range(0, 9));
         step(ev, 1'($urandom), rnd_hdr(), we, a, $urandom, "", ($urandom_range(0, 3) != 0),
              ($urandom_range(0, 3) != 0), ($urandom_range(0, 3) != 0));
      end
      idle_rd(4'd0, "");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule